// File: doc/BRIEF.md
# Element-Pointer-Relative Short Load/Store Unit

This block handles the compact 16-bit load and store forms that address memory at a small positive offset from a dedicated element-pointer register. From one instruction halfword it works out whether the access is a load or a store and whether it moves a byte, a halfword or a word. It rebuilds the displacement, which the encoding keeps pre-scaled with a field width that depends on the size. It then adds that displacement to the element pointer to form the effective address.

Requests go to a little-endian 32-bit data bus. Each request carries byte enables taken from the access size and the low address bits. Store data is copied into every lane, so the enabled lane always holds the right byte or halfword. On a load, the block picks the addressed lane out of the returned bus word. It sign-extends byte and halfword values and passes words through unchanged. The result is handed to the register file together with the destination register index.

Stores appear on the bus one clock after issue. Loads appear on the bus one clock after issue and write back one clock later, two clocks in all. The memory is expected to present read data during the cycle in which the request is shown.

Top module: `eprel_ls`

## Requirements
- R1: The destination or source data register index is taken from instruction bits 15:11. A load writes back to that index (`wb_reg`).
- R2: Bits 10:7 = 0110 is a byte load and 0111 is a byte store. The displacement is bits 6:0, zero-extended (0 to 127).
- R3: Bits 10:7 = 1000 is a halfword load and 1001 is a halfword store. The displacement is bits 6:0 shifted left by one (0 to 254, even).
- R4: Bits 10:7 = 1010 is a word access. The displacement is bits 6:1 shifted left by two (0 to 252). Bit 0 = 0 makes it a load and bit 0 = 1 makes it a store. A word access enables all four lanes (`req_be` = 1111).
- R5: `req_addr` is the element pointer plus the displacement, modulo 2^32 (it wraps past 0xFFFFFFFF).
- R6: Byte enables follow little-endian lanes, with bit n marking byte lane n. A byte access enables only lane addr[1:0]. A halfword access enables 0011 when addr[1] = 0 and 1100 when addr[1] = 1.
- R7: Store data on `req_wdata` is the low byte of the source copied into all four lanes, the low halfword copied into both halves, or the full word.
- R8: Load writeback takes the byte at lane addr[1:0], or the halfword at addr[1], and sign-extends it to 32 bits. A word is written back unchanged.
- R9: A store issued at clock edge k shows `req_vld` = 1 and `req_wr` = 1 right after edge k, and produces no writeback.
- R10: A load issued at edge k shows `req_vld` = 1 and `req_wr` = 0 right after edge k. It shows `wb_vld` = 1 with its data right after edge k+1, using the `mem_rdata` sampled at edge k+1. Back-to-back issues are accepted every cycle.
- R11: An opcode in bits 10:7 outside the five listed above, or `issue_vld` = 0, produces no request and no writeback.
- R12: A synchronous active-low reset clears `req_vld` and `wb_vld`, including for a load that is already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_vld | input | 1 | Instruction halfword is valid this cycle |
| issue_hw | input | 16 | Instruction halfword |
| ep_val | input | 32 | Element-pointer register value |
| st_src | input | 32 | Data register value (store source) |
| mem_rdata | input | 32 | Bus read data for the request currently shown |
| req_vld | output | 1 | Memory request valid |
| req_wr | output | 1 | 1 = store, 0 = load |
| req_addr | output | 32 | Effective byte address |
| req_be | output | 4 | Byte-lane enables |
| req_size | output | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | output | 32 | Lane-replicated store data |
| wb_vld | output | 1 | Register writeback valid |
| wb_reg | output | 5 | Writeback register index |
| wb_data | output | 32 | Extended load value |

## Verification
Request outputs are due one clock after issue, and load writeback is due two clocks after issue. The bench drives every input on a falling edge. It checks request fields on the falling edge after the first rising edge, and presents load data at that same moment. It checks writeback on the falling edge after the second rising edge, so each value is read half a cycle after the register that produces it updates. A back-to-back case checks a store request and the previous load's writeback in the same cycle. Reset cases check the cycle in which reset lands on an in-flight load.

// File: rtl/eprel_pkg.sv
// eprel_pkg: shared types for the element-pointer-relative load/store unit.
// Assumes a 32-bit little-endian data bus with four byte lanes.
package eprel_pkg;

    // access width code, also driven on req_size
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    // opcode values in instruction bits 10:7
    localparam logic [3:0] OPC_LDB = 4'b0110;
    localparam logic [3:0] OPC_STB = 4'b0111;
    localparam logic [3:0] OPC_LDH = 4'b1000;
    localparam logic [3:0] OPC_STH = 4'b1001;
    localparam logic [3:0] OPC_WRD = 4'b1010;

endpackage

// File: rtl/eprel_decode.sv
// eprel_decode: splits a compact instruction halfword into hit, direction,
// size, register index and rebuilt (unscaled) displacement.
// Assumes: register index in bits 15:11, opcode in 10:7, offset field in 6:0.
module eprel_decode
    import eprel_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter int DISP_W = 8
) (
    input  logic [15:0]       hw,
    output logic              hit,
    output logic              is_store,
    output acc_size_e         size,
    output logic [REG_W-1:0]  rd_idx,
    output logic [DISP_W-1:0] disp
);

    localparam int FLD_W = 7;

    logic [3:0]       opc;
    logic [FLD_W-1:0] fld;

    assign opc    = hw[10:7];
    assign fld    = hw[FLD_W-1:0];
    assign rd_idx = hw[15:11];

    // classify opcode and rescale the offset field by access size
    always_comb begin
        hit      = 1'b1;
        is_store = 1'b0;
        size     = SZ_BYTE;
        disp     = '0;
        unique case (opc)
            OPC_LDB, OPC_STB: begin
                size     = SZ_BYTE;
                is_store = (opc == OPC_STB);
                disp     = DISP_W'(fld);
            end
            OPC_LDH, OPC_STH: begin
                size     = SZ_HALF;
                is_store = (opc == OPC_STH);
                disp     = DISP_W'({fld, 1'b0});
            end
            OPC_WRD: begin
                size     = SZ_WORD;
                is_store = fld[0];
                disp     = DISP_W'({fld[FLD_W-1:1], 2'b00});
            end
            default: begin
                hit = 1'b0;
            end
        endcase
    end

    // R3
    always_comb begin
        if (hit && size == SZ_HALF)
            half_even_chk: assert (disp[0] == 1'b0);
    end

    // R4
    always_comb begin
        if (hit && size == SZ_WORD)
            word_align_chk: assert (disp[1:0] == 2'b00);
    end

endmodule

// File: rtl/eprel_agen.sv
// eprel_agen: effective address = base + zero-extended displacement, and
// little-endian byte enables from access size and low address bits.
// Assumes halfword and word accesses are naturally aligned by software.
module eprel_agen
    import eprel_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DISP_W = 8,
    parameter int BE_W   = 4
) (
    input  logic [AW-1:0]     base,
    input  logic [DISP_W-1:0] disp,
    input  acc_size_e         size,
    output logic [AW-1:0]     addr,
    output logic [BE_W-1:0]   be
);

    localparam int LANE_W = $clog2(BE_W);

    logic [LANE_W-1:0] off;

    // modular add, carry out of the top bit is dropped
    assign addr = base + {{(AW-DISP_W){1'b0}}, disp};
    assign off  = addr[LANE_W-1:0];

    // pick the enabled lanes for the access size
    always_comb begin
        unique case (size)
            SZ_BYTE: be = BE_W'(1) << off;
            SZ_HALF: be = BE_W'(3) << {off[LANE_W-1:1], 1'b0};
            default: be = '1;
        endcase
    end

    // R6
    always_comb begin
        if (size == SZ_BYTE)
            byte_lane_chk: assert ($countones(be) == 1);
    end

endmodule

// File: rtl/eprel_lane.sv
// eprel_lane: store side copies the source into every lane; load side picks
// the addressed lane from the bus word and extends it to full width.
// Assumes DW = 32 (four byte lanes, word = whole bus).
module eprel_lane
    import eprel_pkg::*;
#(
    parameter int DW = 32
) (
    input  acc_size_e                 st_size,
    input  logic [DW-1:0]             st_src,
    output logic [DW-1:0]             st_bus,
    input  acc_size_e                 ld_size,
    input  logic [$clog2(DW/8)-1:0]   ld_off,
    input  logic [DW-1:0]             ld_bus,
    output logic [DW-1:0]             ld_val
);

    localparam int NBYTE = DW / 8;
    localparam int NHALF = DW / 16;
    localparam int LANE_W = $clog2(NBYTE);

    logic [7:0]  ld_byte;
    logic [15:0] ld_half;

    // replicate the store value across lanes by size
    always_comb begin
        unique case (st_size)
            SZ_BYTE: st_bus = {NBYTE{st_src[7:0]}};
            SZ_HALF: st_bus = {NHALF{st_src[15:0]}};
            default: st_bus = st_src;
        endcase
    end

    assign ld_byte = ld_bus[{ld_off, 3'b000} +: 8];
    assign ld_half = ld_bus[{ld_off[LANE_W-1:1], 4'b0000} +: 16];

    // sign-extend narrow loads, pass words through
    always_comb begin
        unique case (ld_size)
            SZ_BYTE: ld_val = {{(DW-8){ld_byte[7]}}, ld_byte};
            SZ_HALF: ld_val = {{(DW-16){ld_half[15]}}, ld_half};
            default: ld_val = ld_bus;
        endcase
    end

endmodule

// File: rtl/eprel_ls.sv
// eprel_ls: top of the element-pointer-relative short load/store unit.
// Stage 1 registers the bus request one clock after issue; stage 2 registers
// load writeback one clock later from the read data shown with the request.
// Assumes memory returns read data in the cycle the request is visible.
module eprel_ls
    import eprel_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int REG_W  = 5,
    parameter int DISP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_vld,
    input  logic [15:0]       issue_hw,
    input  logic [AW-1:0]     ep_val,
    input  logic [DW-1:0]     st_src,
    input  logic [DW-1:0]     mem_rdata,
    output logic              req_vld,
    output logic              req_wr,
    output logic [AW-1:0]     req_addr,
    output logic [DW/8-1:0]   req_be,
    output logic [1:0]        req_size,
    output logic [DW-1:0]     req_wdata,
    output logic              wb_vld,
    output logic [REG_W-1:0]  wb_reg,
    output logic [DW-1:0]     wb_data
);

    localparam int BE_W   = DW / 8;
    localparam int LANE_W = $clog2(BE_W);

    logic              d_hit;
    logic              d_store;
    acc_size_e         d_size;
    logic [REG_W-1:0]  d_reg;
    logic [DISP_W-1:0] d_disp;
    logic [AW-1:0]     a_addr;
    logic [BE_W-1:0]   a_be;
    logic [DW-1:0]     st_bus;
    logic [DW-1:0]     ld_val;

    acc_size_e         req_size_q;
    logic [REG_W-1:0]  req_reg_q;

    eprel_decode #(.REG_W(REG_W), .DISP_W(DISP_W)) u_dec (
        .hw       (issue_hw),
        .hit      (d_hit),
        .is_store (d_store),
        .size     (d_size),
        .rd_idx   (d_reg),
        .disp     (d_disp)
    );

    eprel_agen #(.AW(AW), .DISP_W(DISP_W), .BE_W(BE_W)) u_agen (
        .base (ep_val),
        .disp (d_disp),
        .size (d_size),
        .addr (a_addr),
        .be   (a_be)
    );

    eprel_lane #(.DW(DW)) u_lane (
        .st_size (d_size),
        .st_src  (st_src),
        .st_bus  (st_bus),
        .ld_size (req_size_q),
        .ld_off  (req_addr[LANE_W-1:0]),
        .ld_bus  (mem_rdata),
        .ld_val  (ld_val)
    );

    // stage 1: register the bus request for a recognised issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_vld    <= 1'b0;
            req_wr     <= 1'b0;
            req_addr   <= '0;
            req_be     <= '0;
            req_size_q <= SZ_BYTE;
            req_wdata  <= '0;
            req_reg_q  <= '0;
        end else begin
            req_vld    <= issue_vld && d_hit;
            req_wr     <= d_store;
            req_addr   <= a_addr;
            req_be     <= a_be;
            req_size_q <= d_size;
            req_wdata  <= st_bus;
            req_reg_q  <= d_reg;
        end
    end

    // stage 2: capture extended read data for a load request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_vld  <= 1'b0;
            wb_reg  <= '0;
            wb_data <= '0;
        end else begin
            wb_vld  <= req_vld && !req_wr;
            wb_reg  <= req_reg_q;
            wb_data <= ld_val;
        end
    end

    assign req_size = req_size_q;

    // R9
    store_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_wr) |=> !wb_vld);

    // R10
    load_wb_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_wr) |=> wb_vld);

    // R10
    wb_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_vld |-> $past(req_vld && !req_wr));

    // R4
    word_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_size_q == SZ_WORD) |-> req_be == '1);

    // R8
    byte_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_wr && req_size_q == SZ_BYTE)
        |=> wb_data[DW-1:8] == {(DW-8){wb_data[7]}});

endmodule

// File: tb/sim_eprel_ls.sv
`timescale 1ns/1ps
module sim_eprel_ls;

    typedef struct packed {
        logic [15:0] hw;
        logic [31:0] ep;
        logic [31:0] src;
        logic [31:0] rd;
        logic        ev;
        logic        ewr;
        logic [31:0] eaddr;
        logic [3:0]  ebe;
        logic [31:0] ewd;
        logic        ewbv;
        logic [4:0]  ereg;
        logic [31:0] ewb;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        // R2 R6 R8: byte load lane 1, negative
        '{16'h1B05, 32'h1000_0000, 32'h0, 32'h1122_8044, 1'b1, 1'b0, 32'h1000_0005, 4'b0010, 32'h0, 1'b1, 5'd3,  32'hFFFF_FF80, 4'd2},
        // R2: byte load max offset, positive, lane 3
        '{16'h3B7F, 32'h0000_0100, 32'h0, 32'h7A00_0000, 1'b1, 1'b0, 32'h0000_017F, 4'b1000, 32'h0, 1'b1, 5'd7,  32'h0000_007A, 4'd2},
        // R7: byte store replicated
        '{16'h4B82, 32'h2000_0000, 32'hDEAD_BE5A, 32'h0, 1'b1, 1'b1, 32'h2000_0002, 4'b0100, 32'h5A5A_5A5A, 1'b0, 5'd0, 32'h0, 4'd7},
        // R3: halfword load max offset, upper half negative
        '{16'h0C7F, 32'h0000_0000, 32'h0, 32'h8001_1234, 1'b1, 1'b0, 32'h0000_00FE, 4'b1100, 32'h0, 1'b1, 5'd1,  32'hFFFF_8001, 4'd3},
        // R3 R6: halfword load lower half
        '{16'h1410, 32'h4000_0000, 32'h0, 32'hAAAA_9ABC, 1'b1, 1'b0, 32'h4000_0020, 4'b0011, 32'h0, 1'b1, 5'd2,  32'hFFFF_9ABC, 4'd6},
        // R7: halfword store replicated
        '{16'hF483, 32'h0000_1000, 32'h1234_CAFE, 32'h0, 1'b1, 1'b1, 32'h0000_1006, 4'b1100, 32'hCAFE_CAFE, 1'b0, 5'd0, 32'h0, 4'd7},
        // R4 R8: word load, max offset, no extension
        '{16'hFD7E, 32'h8000_0000, 32'h0, 32'h8765_4321, 1'b1, 1'b0, 32'h8000_00FC, 4'b1111, 32'h0, 1'b1, 5'd31, 32'h8765_4321, 4'd4},
        // R4 R5: word store with address wrap
        '{16'h0505, 32'hFFFF_FFF8, 32'h0BAD_F00D, 32'h0, 1'b1, 1'b1, 32'h0000_0000, 4'b1111, 32'h0BAD_F00D, 1'b0, 5'd0, 32'h0, 4'd5},
        // R11: opcode 0100 unrecognised
        '{16'h1A00, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 4'b0, 32'h0, 1'b0, 5'd0, 32'h0, 4'd11},
        // R5: byte load carry into upper bits, lane 0
        '{16'h2301, 32'h0000_FFFF, 32'h0, 32'h0000_00FF, 1'b1, 1'b0, 32'h0001_0000, 4'b0001, 32'h0, 1'b1, 5'd4,  32'hFFFF_FFFF, 4'd5},
        // R11: opcode 1011 unrecognised
        '{16'h0580, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 4'b0, 32'h0, 1'b0, 5'd0, 32'h0, 4'd11},
        // R6 R7: byte store lane 3
        '{16'h2BFB, 32'h0000_0000, 32'h0000_00C3, 32'h0, 1'b1, 1'b1, 32'h0000_007B, 4'b1000, 32'hC3C3_C3C3, 1'b0, 5'd0, 32'h0, 4'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_vld = 1'b0;
    logic [15:0] issue_hw = '0;
    logic [31:0] ep_val = '0;
    logic [31:0] st_src = '0;
    logic [31:0] mem_rdata = '0;
    logic        req_vld, req_wr, wb_vld;
    logic [31:0] req_addr, req_wdata, wb_data;
    logic [3:0]  req_be;
    logic [1:0]  req_size;
    logic [4:0]  wb_reg;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    eprel_ls u0 (
        .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .issue_hw(issue_hw),
        .ep_val(ep_val), .st_src(st_src), .mem_rdata(mem_rdata),
        .req_vld(req_vld), .req_wr(req_wr), .req_addr(req_addr), .req_be(req_be),
        .req_size(req_size), .req_wdata(req_wdata), .wb_vld(wb_vld),
        .wb_reg(wb_reg), .wb_data(wb_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [15:0] hw, input logic [31:0] ep,
                         input logic [31:0] src);
        issue_vld = v;
        issue_hw  = hw;
        ep_val    = ep;
        st_src    = src;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        string t;
        @(negedge clk);
        drive(1'b1, v.hw, v.ep, v.src);
        mem_rdata = '0;
        @(negedge clk);
        drive(1'b0, 16'h0, 32'h0, 32'h0);
        mem_rdata = v.rd;
        t = $sformatf("R%0d vec%0d", v.rq, idx);
        chk({t, " req_vld"}, 32'(req_vld), 32'(v.ev));
        if (v.ev) begin
            chk({t, " req_wr"}, 32'(req_wr), 32'(v.ewr));
            chk({t, " req_addr"}, req_addr, v.eaddr);
            chk({t, " req_be"}, 32'(req_be), 32'(v.ebe));
            if (v.ewr) chk({t, " req_wdata"}, req_wdata, v.ewd);
        end
        @(negedge clk);
        mem_rdata = '0;
        chk({t, " wb_vld"}, 32'(wb_vld), 32'(v.ewbv));
        if (v.ewbv) begin
            chk({t, " wb_reg R1"}, 32'(wb_reg), 32'(v.ereg));
            chk({t, " wb_data"}, wb_data, v.ewb);
        end
    endtask

    initial begin
        // R12: reset holds outputs idle even with a load presented
        drive(1'b1, 16'h1B05, 32'h1000_0000, 32'h0);
        repeat (3) @(negedge clk);
        chk("R12 req_vld in reset", 32'(req_vld), 32'd0);
        chk("R12 wb_vld in reset", 32'(wb_vld), 32'd0);
        drive(1'b0, 16'h0, 32'h0, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

        // R11: valid opcode with issue_vld low gives nothing
        @(negedge clk);
        drive(1'b0, 16'hFD7E, 32'h8000_0000, 32'h0);
        @(negedge clk);
        chk("R11 no issue req_vld", 32'(req_vld), 32'd0);
        @(negedge clk);
        chk("R11 no issue wb_vld", 32'(wb_vld), 32'd0);

        // R10 R9: load then store back-to-back
        drive(1'b1, 16'h1B05, 32'h1000_0000, 32'h0);
        @(negedge clk);
        drive(1'b1, 16'h4B82, 32'h2000_0000, 32'hDEAD_BE5A);
        mem_rdata = 32'h1122_8044;
        chk("R10 b2b load req_addr", req_addr, 32'h1000_0005);
        @(negedge clk);
        drive(1'b0, 16'h0, 32'h0, 32'h0);
        mem_rdata = '0;
        chk("R9 b2b store req_wr", 32'(req_wr), 32'd1);
        chk("R9 b2b store req_addr", req_addr, 32'h2000_0002);
        chk("R10 b2b load wb_vld", 32'(wb_vld), 32'd1);
        chk("R10 b2b load wb_data", wb_data, 32'hFFFF_FF80);
        @(negedge clk);
        chk("R9 store gives no wb", 32'(wb_vld), 32'd0);

        // R12: reset lands on an in-flight load
        drive(1'b1, 16'hFD7E, 32'h8000_0000, 32'h0);
        @(negedge clk);
        drive(1'b0, 16'h0, 32'h0, 32'h0);
        mem_rdata = 32'h8765_4321;
        chk("R10 word load req_vld", 32'(req_vld), 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R12 in-flight wb_vld cleared", 32'(wb_vld), 32'd0);
        chk("R12 req_vld cleared", 32'(req_vld), 32'd0);
        rst_n = 1'b1;
        mem_rdata = '0;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R10 actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule